// File: doc/BRIEF.md
# DMA Channel Mask and Status Register Unit

This unit keeps the per-channel request mask and the per-channel status flags of a four-channel DMA controller. A processor reaches it over an 8-bit data bus using one-cycle strobes: a whole-mask load, a command that sets or clears the mask bit of a single channel, a master clear, a mask read and a status read. Read data is driven combinationally while a read strobe is high. It returns zero when no read strobe is active.

The unit watches four raw request lines and gates them with the mask. The gated lines go to a separate priority arbiter. Terminal-count pulses from the transfer sequencer set sticky flags. An end-of-process pulse, together with its channel index, sets the same flags. A status read returns the flags and clears them in the same operation. Each status request bit follows its raw request input one cycle late, whatever the state of the mask.

Top module: `dmac_mask_status`

## Requirements
- R1: Reset (synchronous, active high) leaves the mask at 1111 and all status bits at 0. A mask read then returns 0xFF and a status read with no requests returns 0x00.
- R2: `mask_wr` loads mask bit n from `wr_data[n]` for n = 0..3. `wr_data[7:4]` is ignored.
- R3: While `mask_rd` is high, `rd_data` equals {4'b1111, mask[3:0]}, where mask bit n = 1 means channel n is masked.
- R4: `single_mask_wr` writes `wr_data[2]` into the mask bit of the channel selected by `wr_data[1:0]`. The other three bits do not change. If `mask_wr` is high in the same cycle, the whole-mask load wins and the single command is dropped.
- R5: `master_clr` sets the mask to 1111 and clears every status bit on the next edge. It overrides any mask write and any terminal-count event in the same cycle.
- R6: `req_masked[n]` is `req_in[n]` AND NOT mask bit n, with no register on the path.
- R7: A `tc_pulse[n]` sets terminal-count flag n (status bit n) at the next edge. The flag stays set until a status read.
- R8: An `eop_pulse` sets the terminal-count flag of the channel given by `eop_chan`.
- R9: While `status_rd` is high, `rd_data` returns the flags as held before the read: bits 3..0 are the terminal-count flags of channels 0..3 and bits 7..4 are the request flags of channels 0..3. All terminal-count flags clear at the following edge.
- R10: A terminal-count event in the same cycle as a status read stays set after that read.
- R11: Request flag n (status bit 4+n) holds the value `req_in[n]` had at the previous edge, whether channel n is masked or not.
- R12: With neither read strobe high, `rd_data` is 0x00. If both read strobes are high, the mask read wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | 8 | Processor write data |
| mask_wr | input | 1 | Whole-mask load strobe |
| single_mask_wr | input | 1 | Single-channel mask command strobe |
| master_clr | input | 1 | Master clear strobe |
| mask_rd | input | 1 | Mask read strobe |
| status_rd | input | 1 | Status read strobe (clears terminal-count flags) |
| req_in | input | 4 | Raw per-channel request lines |
| tc_pulse | input | 4 | Per-channel terminal-count pulses |
| eop_pulse | input | 1 | External end-of-process pulse |
| eop_chan | input | 2 | Channel index for the end-of-process pulse |
| rd_data | output | 8 | Read data |
| req_masked | output | 4 | Mask-gated requests for the arbiter |

## Verification
A wrong mask bit shows at the ports in two places. It appears on `req_masked` as soon as the matching request is raised, and in the low nibble of the next mask read. A lost or stuck terminal-count flag cannot be seen until the next status read. For that reason every event is followed by a read, and a second read then checks that the flags cleared. The event-during-read case is checked across two consecutive reads, because the flag sits one read late.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int NUM_CH = 4;
    localparam int DATA_W = 8;
    localparam int SEL_W  = $clog2(NUM_CH);

    typedef logic [NUM_CH-1:0] chan_vec_t;

    // Mask update selected for the current cycle, in priority order.
    typedef enum logic [1:0] {
        MOP_HOLD,
        MOP_SET_ALL,
        MOP_LOAD,
        MOP_SINGLE
    } mask_op_e;

    // Fields of the single-channel mask command.
    typedef struct packed {
        logic             val;
        logic [SEL_W-1:0] sel;
    } single_cmd_t;

    function automatic chan_vec_t chan_decode(input logic [SEL_W-1:0] sel);
        chan_vec_t v;
        v = '0;
        v[sel] = 1'b1;
        return v;
    endfunction

    function automatic single_cmd_t unpack_single(input logic [DATA_W-1:0] d);
        single_cmd_t c;
        c.sel = d[SEL_W-1:0];
        c.val = d[SEL_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] mask_readback(input chan_vec_t m);
        return {{(DATA_W-NUM_CH){1'b1}}, m};
    endfunction

    function automatic mask_op_e pick_mask_op(input logic clr, input logic load,
                                              input logic single);
        if (clr)         return MOP_SET_ALL;
        else if (load)   return MOP_LOAD;
        else if (single) return MOP_SINGLE;
        else             return MOP_HOLD;
    endfunction

endpackage

// File: rtl/dmac_mask_reg.sv
module dmac_mask_reg
    import dmac_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int DW   = DATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  mask_op_e        op,
    input  logic [DW-1:0]   data,
    output logic [N_CH-1:0] mask_q
);
    single_cmd_t     cmd;
    logic [N_CH-1:0] sel_vec;
    logic [N_CH-1:0] mask_d;

    always_comb begin
        cmd     = unpack_single(data);
        sel_vec = chan_decode(cmd.sel);
        unique case (op)
            MOP_SET_ALL: mask_d = '1;
            MOP_LOAD:    mask_d = data[N_CH-1:0];
            MOP_SINGLE:  mask_d = cmd.val ? (mask_q | sel_vec) : (mask_q & ~sel_vec);
            default:     mask_d = mask_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '1;
        else     mask_q <= mask_d;
    end
endmodule

// File: rtl/dmac_event_merge.sv
module dmac_event_merge
    import dmac_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int SW   = SEL_W
) (
    input  logic [N_CH-1:0] tc_pulse,
    input  logic            eop_pulse,
    input  logic [SW-1:0]   eop_chan,
    output logic [N_CH-1:0] evt
);
    logic [N_CH-1:0] eop_vec;

    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_ch
            assign eop_vec[i] = eop_pulse && (eop_chan == SW'(i));
        end
    endgenerate

    assign evt = tc_pulse | eop_vec;
endmodule

// File: rtl/dmac_status_reg.sv
module dmac_status_reg
    import dmac_pkg::*;
#(
    parameter int N_CH = NUM_CH
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            rd_clr,
    input  logic [N_CH-1:0] evt,
    input  logic [N_CH-1:0] req_in,
    output logic [N_CH-1:0] tc_q,
    output logic [N_CH-1:0] req_q
);
    // Per-channel sticky flag; a same-cycle event beats the read clear.
    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    tc_q[i]  <= 1'b0;
                    req_q[i] <= 1'b0;
                end else begin
                    tc_q[i]  <= evt[i] | (tc_q[i] & ~rd_clr);
                    req_q[i] <= req_in[i];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/dmac_rd_mux.sv
module dmac_rd_mux
    import dmac_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int DW   = DATA_W
) (
    input  logic            mask_rd,
    input  logic            status_rd,
    input  logic [N_CH-1:0] mask_q,
    input  logic [N_CH-1:0] tc_q,
    input  logic [N_CH-1:0] req_q,
    output logic [DW-1:0]   rd_data
);
    always_comb begin
        if (mask_rd)        rd_data = mask_readback(mask_q);
        else if (status_rd) rd_data = {req_q, tc_q};
        else                rd_data = '0;
    end
endmodule

// File: rtl/dmac_mask_status.sv
module dmac_mask_status
    import dmac_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int DW   = DATA_W,
    parameter int SW   = SEL_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DW-1:0]   wr_data,
    input  logic            mask_wr,
    input  logic            single_mask_wr,
    input  logic            master_clr,
    input  logic            mask_rd,
    input  logic            status_rd,
    input  logic [N_CH-1:0] req_in,
    input  logic [N_CH-1:0] tc_pulse,
    input  logic            eop_pulse,
    input  logic [SW-1:0]   eop_chan,
    output logic [DW-1:0]   rd_data,
    output logic [N_CH-1:0] req_masked
);
    mask_op_e        mask_op;
    logic [N_CH-1:0] mask_q;
    logic [N_CH-1:0] tc_q;
    logic [N_CH-1:0] req_q;
    logic [N_CH-1:0] evt;

    assign mask_op = pick_mask_op(master_clr, mask_wr, single_mask_wr);

    dmac_mask_reg #(.N_CH(N_CH), .DW(DW)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .op     (mask_op),
        .data   (wr_data),
        .mask_q (mask_q)
    );

    dmac_event_merge #(.N_CH(N_CH), .SW(SW)) u_evt (
        .tc_pulse  (tc_pulse),
        .eop_pulse (eop_pulse),
        .eop_chan  (eop_chan),
        .evt       (evt)
    );

    dmac_status_reg #(.N_CH(N_CH)) u_status (
        .clk    (clk),
        .rst    (rst),
        .clr    (master_clr),
        .rd_clr (status_rd),
        .evt    (evt),
        .req_in (req_in),
        .tc_q   (tc_q),
        .req_q  (req_q)
    );

    dmac_rd_mux #(.N_CH(N_CH), .DW(DW)) u_rd (
        .mask_rd   (mask_rd),
        .status_rd (status_rd),
        .mask_q    (mask_q),
        .tc_q      (tc_q),
        .req_q     (req_q),
        .rd_data   (rd_data)
    );

    assign req_masked = req_in & ~mask_q;
endmodule

// File: rtl/dmac_mask_status_chk.sv
module dmac_mask_status_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] wr_data,
    input logic       mask_wr,
    input logic       single_mask_wr,
    input logic       master_clr,
    input logic       mask_rd,
    input logic       status_rd,
    input logic [3:0] req_in,
    input logic [3:0] evt,
    input logic [3:0] mask_q,
    input logic [3:0] tc_q,
    input logic [3:0] req_q,
    input logic [7:0] rd_data,
    input logic [3:0] req_masked
);
    assert_mask_read_R3: assert property (@(posedge clk) disable iff (rst)
        mask_rd |-> rd_data == {4'hF, mask_q});

    assert_single_keeps_others_R4: assert property (@(posedge clk) disable iff (rst)
        (single_mask_wr && !mask_wr && !master_clr) |=>
        (((mask_q ^ $past(mask_q)) & ~(4'b0001 << $past(wr_data[1:0]))) == 4'b0000));

    assert_master_clear_R5: assert property (@(posedge clk) disable iff (rst)
        master_clr |=> (mask_q == 4'hF && tc_q == 4'h0 && req_q == 4'h0));

    assert_gate_blocks_masked_R6: assert property (@(posedge clk) disable iff (rst)
        ((req_masked & mask_q) == 4'h0) && ((req_masked & ~req_in) == 4'h0));

    assert_event_sets_flag_R7: assert property (@(posedge clk) disable iff (rst)
        !master_clr |=> ((tc_q & $past(evt)) == $past(evt)));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !master_clr) |=> tc_q == $past(evt));

    assert_req_follows_R11: assert property (@(posedge clk) disable iff (rst)
        !master_clr |=> req_q == $past(req_in));

    assert_idle_bus_R12: assert property (@(posedge clk) disable iff (rst)
        (!mask_rd && !status_rd) |-> rd_data == 8'h00);
endmodule

bind dmac_mask_status dmac_mask_status_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .wr_data        (wr_data),
    .mask_wr        (mask_wr),
    .single_mask_wr (single_mask_wr),
    .master_clr     (master_clr),
    .mask_rd        (mask_rd),
    .status_rd      (status_rd),
    .req_in         (req_in),
    .evt            (evt),
    .mask_q         (mask_q),
    .tc_q           (tc_q),
    .req_q          (req_q),
    .rd_data        (rd_data),
    .req_masked     (req_masked)
);

// File: tb/dmac_mask_status_tb.sv
module dmac_mask_status_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] wr_data = '0;
    logic       mask_wr = 1'b0, single_mask_wr = 1'b0, master_clr = 1'b0;
    logic       mask_rd = 1'b0, status_rd = 1'b0;
    logic [3:0] req_in = '0, tc_pulse = '0;
    logic       eop_pulse = 1'b0;
    logic [1:0] eop_chan = '0;
    logic [7:0] rd_data;
    logic [3:0] req_masked;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    dmac_mask_status u_dut (
        .clk(clk), .rst(rst), .wr_data(wr_data), .mask_wr(mask_wr),
        .single_mask_wr(single_mask_wr), .master_clr(master_clr),
        .mask_rd(mask_rd), .status_rd(status_rd), .req_in(req_in),
        .tc_pulse(tc_pulse), .eop_pulse(eop_pulse), .eop_chan(eop_chan),
        .rd_data(rd_data), .req_masked(req_masked)
    );

    // {single_cmd, wr_data, expected mask readback}
    localparam logic [16:0] VEC [9] = '{
        {1'b0, 8'hA5, 8'hF5},
        {1'b1, 8'h05, 8'hF7},
        {1'b1, 8'h00, 8'hF6},
        {1'b1, 8'hFB, 8'hF6},
        {1'b1, 8'h07, 8'hFE},
        {1'b0, 8'h30, 8'hF0},
        {1'b1, 8'h06, 8'hF4},
        {1'b0, 8'hFF, 8'hFF},
        {1'b1, 8'h02, 8'hFB}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic mw, input logic sw, input logic mc, input logic [7:0] d);
        @(negedge clk);
        mask_wr = mw; single_mask_wr = sw; master_clr = mc; wr_data = d;
        @(negedge clk);
        mask_wr = 1'b0; single_mask_wr = 1'b0; master_clr = 1'b0; wr_data = '0;
    endtask

    task automatic rd_mask(output logic [7:0] v);
        @(negedge clk);
        mask_rd = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        mask_rd = 1'b0;
    endtask

    task automatic rd_status(input logic [3:0] tc_same, output logic [7:0] v);
        @(negedge clk);
        status_rd = 1'b1; tc_pulse = tc_same;
        #1 v = rd_data;
        @(negedge clk);
        status_rd = 1'b0; tc_pulse = '0;
    endtask

    task automatic pulse(input logic [3:0] t, input logic e, input logic [1:0] ch);
        @(negedge clk);
        tc_pulse = t; eop_pulse = e; eop_chan = ch;
        @(negedge clk);
        tc_pulse = '0; eop_pulse = 1'b0; eop_chan = '0;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd_mask(v);          check("R1 mask after reset", v, 8'hFF);
        rd_status(4'h0, v);  check("R1 status after reset", v, 8'h00);
        @(negedge clk) req_in = 4'hF;
        #1 check("R1/R6 all masked after reset", {4'h0, req_masked}, 8'h00);
        @(negedge clk) req_in = 4'h0;

        // R2 R3 R4 R6: table walk
        for (int i = 0; i < 9; i++) begin
            wr(!VEC[i][16], VEC[i][16], 1'b0, VEC[i][15:8]);
            rd_mask(v);
            check(VEC[i][16] ? "R4 single mask" : "R2/R3 whole mask", v, VEC[i][7:0]);
            @(negedge clk) req_in = 4'hF;
            #1 check("R6 gated requests", {4'h0, req_masked}, {4'h0, ~VEC[i][3:0]});
            @(negedge clk) req_in = 4'h0;
        end

        // R4 priority: whole load beats single command
        @(negedge clk);
        mask_wr = 1'b1; single_mask_wr = 1'b1; wr_data = 8'h03;
        @(negedge clk);
        mask_wr = 1'b0; single_mask_wr = 1'b0; wr_data = '0;
        rd_mask(v);          check("R4 load wins over single", v, 8'hF3);

        // R7 sticky terminal count, R9 read clears
        pulse(4'b0101, 1'b0, 2'd0);
        @(negedge clk);
        rd_status(4'h0, v);  check("R7 tc flags sticky", v, 8'h05);
        rd_status(4'h0, v);  check("R9 flags cleared by read", v, 8'h00);

        // R8 end-of-process
        pulse(4'h0, 1'b1, 2'd2);
        rd_status(4'h0, v);  check("R8 eop sets channel 2", v, 8'h04);

        // R11 request flags unaffected by mask (mask is 0011)
        @(negedge clk) req_in = 4'b1011;
        rd_status(4'h0, v);  check("R11 raw request in status", v, 8'hB0);
        check("R6 masked channels 0,1 blocked", {4'h0, req_masked}, 8'h08);
        @(negedge clk) req_in = 4'h0;

        // R10 event during read survives
        pulse(4'b0001, 1'b0, 2'd0);
        rd_status(4'b1000, v); check("R10 read returns pre-event value", v, 8'h01);
        rd_status(4'h0, v);    check("R10 same-cycle event kept", v, 8'h08);
        rd_status(4'h0, v);    check("R9 cleared after second read", v, 8'h00);

        // R5 master clear beats write and event
        wr(1'b1, 1'b0, 1'b0, 8'h00);
        pulse(4'b0010, 1'b0, 2'd0);
        @(negedge clk);
        master_clr = 1'b1; mask_wr = 1'b1; wr_data = 8'h00; tc_pulse = 4'b0100;
        @(negedge clk);
        master_clr = 1'b0; mask_wr = 1'b0; tc_pulse = '0;
        rd_mask(v);          check("R5 mask set by master clear", v, 8'hFF);
        rd_status(4'h0, v);  check("R5 status cleared by master clear", v, 8'h00);

        // R12 idle bus and read priority
        @(negedge clk);
        #1 check("R12 idle read data", rd_data, 8'h00);
        pulse(4'b0001, 1'b0, 2'd0);
        @(negedge clk);
        mask_rd = 1'b1; status_rd = 1'b1;
        #1 check("R12 mask read wins", rd_data, 8'hFF);
        @(negedge clk);
        mask_rd = 1'b0; status_rd = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule